// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block merges two sources of interrupt requests into one pending priority level. The first source is a software request register. Its request bits sit in a contiguous field, and each bit is renumbered to a small level that counts up from 1. The second source is a vector of external interrupt lines. Each line in its scanned field uses its own bit index as its level. Both fields are scanned in a fixed order: software bits first, lowest to highest, then external bits, lowest to highest. The last set bit found sets the resolved level, so any pending external line takes priority over every software request.

The resolved level is compared with the current interrupt priority level. When the resolved level is nonzero and strictly greater, the block issues a trap request on the next clock edge. On that same edge it captures the pending-source bitmap and the winning level in two holding registers, which the trap handler reads. The trap output is registered. It is high for every cycle that follows a cycle in which the trap condition held. The consumer ends it by raising the current priority level or by clearing the request. All inputs and outputs are plain control and status pins, so there is no stream interface and no back-pressure.

Top module: `irq_level_resolver`

## Requirements
- R1: A software request bit at index i, with 4 <= i <= 18, gives level i - 3 on `pend_lvl_o` in the same cycle.
- R2: An external line at index i, with 16 <= i <= 31, gives level i on `pend_lvl_o` in the same cycle.
- R3: When several bits are set, the highest set software bit decides among software requests and the highest set external line decides among external lines. Any set external line in 16..31 overrides all software requests.
- R4: `pend_sum_o` is the bitwise OR of the software bits 4..18 and the external bits 16..31, each kept at its own bit position.
- R5: Software bits 0..3 and external bits 0..15 have no effect on `pend_lvl_o`, `pend_sum_o` or any trap.
- R6: When `pend_lvl_o` is nonzero and greater than `cur_ipl_i`, `trap_o` is 1 after the next rising clock edge.
- R7: When `pend_lvl_o` is zero or not greater than `cur_ipl_i`, `trap_o` is 0 after the next rising clock edge.
- R8: On every edge that sets `trap_o`, `sum_reg_o` and `lvl_reg_o` load the pending bitmap and the level. On every other edge they hold their values.
- R9: While `rst_n` is low, `trap_o`, `sum_reg_o` and `lvl_reg_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sw_req_i | input | 19 | Software request register, request field at bits 18..4 |
| ext_irq_i | input | 32 | External interrupt lines, scanned field at bits 31..16 |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| pend_sum_o | output | 32 | Combinational bitmap of pending sources |
| pend_lvl_o | output | 5 | Combinational resolved level, 0 when nothing is pending |
| trap_o | output | 1 | Registered trap request |
| sum_reg_o | output | 32 | Bitmap captured on the last trap |
| lvl_reg_o | output | 5 | Level captured on the last trap |

## Verification
A scan that picks the wrong winner or renumbers software bits wrongly shows up at once on `pend_lvl_o`, in the same cycle as the stimulus. The bench exercises every single bit of both inputs, every pair of software bits, and mixed patterns, so such a fault is exposed. A wrong comparison or a bad capture register appears one edge later on `trap_o`, `sum_reg_o` or `lvl_reg_o`. The bench sweeps every level from 1 to 31 against every priority value from 0 to 31. It also tracks the held register contents across cycles in which no trap occurs.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int unsigned DEF_SW_LO  = 4;
  localparam int unsigned DEF_SW_HI  = 18;
  localparam int unsigned DEF_EXT_LO = 16;
  localparam int unsigned DEF_EXT_HI = 31;
  localparam int unsigned DEF_LVL_W  = 5;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_field_scan.sv
module irq_field_scan #(
  parameter int unsigned IN_W  = 19,
  parameter int unsigned LO    = 4,
  parameter int unsigned HI    = 18,
  parameter int unsigned BASE  = 1,
  parameter int unsigned LVL_W = 5,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  bits_i,
  output logic [OUT_W-1:0] mask_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             any_o
);
  logic unused_in;
  assign unused_in = ^bits_i;

  // The field is scanned upward, and the last set bit sets the level.
  always_comb begin
    lvl_o = '0;
    for (int i = LO; i <= HI; i++) begin
      if (bits_i[i]) lvl_o = LVL_W'(i - LO + BASE);
    end
  end

  assign any_o = |bits_i[HI:LO];

  for (genvar g = 0; g < OUT_W; g++) begin : g_mask
    if (g >= LO && g <= HI && g < IN_W) begin : g_in
      assign mask_o[g] = bits_i[g];
    end else begin : g_out
      assign mask_o[g] = 1'b0;
    end
  end

  // R1 R2: a level is produced exactly when some bit of the field is set
  always_comb begin
    a_r1_level_iff_any : assert ((lvl_o != '0) == any_o);
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned EXT_LO = 16
) (
  input  logic             sw_any_i,
  input  logic [LVL_W-1:0] sw_lvl_i,
  input  logic             ext_any_i,
  input  logic [LVL_W-1:0] ext_lvl_i,
  input  logic [LVL_W-1:0] ipl_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             take_o
);
  // The external scan runs after the software scan, so it wins.
  assign lvl_o  = ext_any_i ? ext_lvl_i : sw_lvl_i;
  assign take_o = (lvl_o != '0) && (lvl_o > ipl_i);

  // R3: when an external line is pending, the level lies in the external range
  always_comb begin
    a_r3_ext_overrides : assert (!ext_any_i || (lvl_o >= LVL_W'(EXT_LO)));
    a_r7_no_take_idle  : assert (sw_any_i || ext_any_i || !take_o);
  end
endmodule

// File: rtl/irq_trap_capture.sv
module irq_trap_capture #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             trap_o,
  output logic [SUM_W-1:0] sum_q_o,
  output logic [LVL_W-1:0] lvl_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_o  <= 1'b0;
      sum_q_o <= '0;
      lvl_q_o <= '0;
    end else begin
      trap_o <= take_i;
      if (take_i) begin
        sum_q_o <= sum_i;
        lvl_q_o <= lvl_i;
      end
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int unsigned SW_LO  = irq_level_pkg::DEF_SW_LO,
  parameter int unsigned SW_HI  = irq_level_pkg::DEF_SW_HI,
  parameter int unsigned EXT_LO = irq_level_pkg::DEF_EXT_LO,
  parameter int unsigned EXT_HI = irq_level_pkg::DEF_EXT_HI,
  parameter int unsigned LVL_W  = irq_level_pkg::DEF_LVL_W
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [SW_HI:0]                                sw_req_i,
  input  logic [EXT_HI:0]                               ext_irq_i,
  input  logic [LVL_W-1:0]                              cur_ipl_i,
  output logic [irq_level_pkg::max_u(SW_HI, EXT_HI):0]  pend_sum_o,
  output logic [LVL_W-1:0]                              pend_lvl_o,
  output logic                                          trap_o,
  output logic [irq_level_pkg::max_u(SW_HI, EXT_HI):0]  sum_reg_o,
  output logic [LVL_W-1:0]                              lvl_reg_o
);
  localparam int unsigned SUM_W = irq_level_pkg::max_u(SW_HI, EXT_HI) + 1;

  logic [SUM_W-1:0] sw_mask, ext_mask;
  logic [LVL_W-1:0] sw_lvl, ext_lvl;
  logic             sw_any, ext_any, take;

  irq_field_scan #(
    .IN_W(SW_HI + 1), .LO(SW_LO), .HI(SW_HI), .BASE(1),
    .LVL_W(LVL_W), .OUT_W(SUM_W)
  ) u_sw_scan (
    .bits_i(sw_req_i), .mask_o(sw_mask), .lvl_o(sw_lvl), .any_o(sw_any)
  );

  irq_field_scan #(
    .IN_W(EXT_HI + 1), .LO(EXT_LO), .HI(EXT_HI), .BASE(EXT_LO),
    .LVL_W(LVL_W), .OUT_W(SUM_W)
  ) u_ext_scan (
    .bits_i(ext_irq_i), .mask_o(ext_mask), .lvl_o(ext_lvl), .any_o(ext_any)
  );

  assign pend_sum_o = sw_mask | ext_mask;

  irq_level_pick #(.LVL_W(LVL_W), .EXT_LO(EXT_LO)) u_pick (
    .sw_any_i(sw_any), .sw_lvl_i(sw_lvl), .ext_any_i(ext_any), .ext_lvl_i(ext_lvl),
    .ipl_i(cur_ipl_i), .lvl_o(pend_lvl_o), .take_o(take)
  );

  irq_trap_capture #(.LVL_W(LVL_W), .SUM_W(SUM_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take_i(take), .sum_i(pend_sum_o), .lvl_i(pend_lvl_o),
    .trap_o(trap_o), .sum_q_o(sum_reg_o), .lvl_q_o(lvl_reg_o)
  );

  // R6: a trap follows only a pending level above the priority
  a_r6_trap_cause : assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(pend_lvl_o) > $past(cur_ipl_i)));
  // R7: an idle or masked level never produces a trap
  a_r7_no_trap : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_lvl_o) <= $past(cur_ipl_i)) |-> !trap_o);
  // R8: the captured values match the pending values at the trap edge
  a_r8_load : assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (lvl_reg_o == $past(pend_lvl_o)) && (sum_reg_o == $past(pend_sum_o)));
  // R8: without a trap the capture registers hold
  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(lvl_reg_o) && $stable(sum_reg_o));
endmodule

// File: tb/irq_level_resolver_tb.sv
`timescale 1ns/1ps
module irq_level_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] sw_req = '0;
  logic [31:0] ext_irq = '0;
  logic [4:0]  ipl = '0;
  logic [31:0] pend_sum, sum_reg;
  logic [4:0]  pend_lvl, lvl_reg;
  logic        trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] m_sum = '0;
  logic [4:0]  m_lvl = '0;

  always #4 clk = ~clk;

  irq_level_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .ext_irq_i(ext_irq), .cur_ipl_i(ipl),
    .pend_sum_o(pend_sum), .pend_lvl_o(pend_lvl), .trap_o(trap),
    .sum_reg_o(sum_reg), .lvl_reg_o(lvl_reg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_lvl(input logic [18:0] s, input logic [31:0] e);
    logic [4:0] l = 5'd0;
    for (int i = 4; i <= 18; i++) if (s[i]) l = 5'(i - 3);
    for (int i = 16; i <= 31; i++) if (e[i]) l = 5'(i);
    return l;
  endfunction

  task automatic apply(input string tag, input logic [18:0] s, input logic [31:0] e,
                       input logic [4:0] p);
    logic [4:0]  el;
    logic [31:0] es;
    logic        et;
    @(negedge clk);
    sw_req = s; ext_irq = e; ipl = p;
    el = exp_lvl(s, e);
    es = {13'd0, s & 19'h7FFF0} | (e & 32'hFFFF_0000);
    et = (el != 0) && (el > p);
    #1;
    chk({tag, " level"}, 32'(pend_lvl), 32'(el));
    chk("R4 summary", pend_sum, es);
    @(negedge clk);
    if (et) begin m_sum = es; m_lvl = el; end
    chk(et ? "R6 trap" : "R7 no trap", 32'(trap), 32'(et));
    chk("R8 captured level", 32'(lvl_reg), 32'(m_lvl));
    chk("R8 captured summary", sum_reg, m_sum);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    chk("R9 reset trap", 32'(trap), 32'd0);
    chk("R9 reset level reg", 32'(lvl_reg), 32'd0);
    chk("R9 reset summary reg", sum_reg, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 19; i++) apply(i < 4 ? "R5 sw low" : "R1 sw single", 19'(1) << i, '0, '0);
    for (int i = 0; i < 32; i++) apply(i < 16 ? "R5 ext low" : "R2 ext single", '0, 32'(1) << i, '0);
    for (int i = 4; i <= 18; i++)
      for (int j = i + 1; j <= 18; j++)
        apply("R3 sw pair", (19'(1) << i) | (19'(1) << j), '0, 5'd2);
    for (int i = 4; i <= 18; i++) apply("R3 ext over sw", 19'h7FFF0, 32'(1) << (i + 12), '0);
    for (int l = 1; l <= 31; l++)
      for (int p = 0; p <= 31; p++)
        if (l <= 15) apply("R6 sweep sw", 19'(1) << (l + 3), '0, 5'(p));
        else         apply("R6 sweep ext", '0, 32'(1) << l, 5'(p));
    apply("R7 idle", '0, '0, '0);
    apply("R5 low only", 19'h0000F, 32'h0000_FFFF, '0);
    for (int k = 0; k < 400; k++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      apply("R3 mixed", r[18:0], (k % 3 == 0) ? (r & 32'h0000_FFFF) : {r[7:0], r[31:8]}, r[27:23]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule